// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. Its pins are split into banks of 32, and each bank carries its own registers. The registers hold the output latch, the per-pin output enables and the rising-edge and falling-edge enables. A sticky edge-status word records the edges that were caught, and a per-bank mask gates which pins may report edges at all. Software drives outputs through separate write-one set and clear ports, so no read-modify-write is needed. It acknowledges caught edges by writing ones back to the status word.

A simple word-wide register bus reaches every bank. The bus has a byte address, a write strobe, write data and registered read data. Banks are interleaved three at a time at 4-byte steps inside each 256-byte group, and register kinds sit at 12-byte strides inside the group. Input pins pass through a two-flop synchronizer before level readback and edge detection. One aggregate interrupt covers every pin, and pins 0 and 1 each also own a dedicated interrupt line.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The base byte address of bank n is ((n / 3) << 8) + ((n % 3) << 2). The register offsets from that base are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48, edge mask 0x9C. The following all read as 0 and ignore writes: the set and clear ports, any other offset, any bank at or beyond the bank count, and any address with bits [1:0] not zero.
- R2: Writing a word to the set port drives the output latch bit high for each 1 bit. Writing to the clear port drives the latch bit low for each 1 bit. Zero bits leave the latch unchanged. `pin_out` shows the latch one cycle after the write.
- R3: A direction bit of 1 makes the pin an output (`pin_oe` high). A direction bit of 0 makes it an input. The direction register reads back as written.
- R4: The level register returns the pin value after a two-flop synchronizer, whatever the pin direction.
- R5: Rising and falling detection are enabled independently per pin. A rising edge is a 0-to-1 change of the synchronized value, and a falling edge is a 1-to-0 change. With both enables set, either change sets the status bit.
- R6: Edge-status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: An edge on a pin whose mask bit is 0 never sets that pin's status bit.
- R8: If a new edge and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: `irq_any` is the OR of every status bit, registered with one cycle of latency. `irq_pin0` and `irq_pin1` follow status bits 0 and 1 of bank 0 with the same latency.
- R10: Reset clears every register to 0, except the edge mask, which resets to all ones. Bits for pins beyond the pin count always read 0 and ignore writes.
- R11: `bus_rdata` returns the register addressed in the previous cycle (one cycle of read latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pin input values |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables (direction) |
| irq_any | output | 1 | Aggregate edge interrupt |
| irq_pin0 | output | 1 | Dedicated interrupt for pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt for pin 1 |

## Verification
The bench places a write-one-to-clear in exactly the cycle where a fresh rising edge lands on pin 0. A design that gives the clear priority would lose that interrupt for good. Other directed cases target edge behaviour:
- a pin with only the falling enable sees a rising edge, which a design with swapped enables would flag;
- a masked pin sees an edge, which a design with a wrong mask polarity would report;
- a zero write to the status word, which would wipe pending edges if zeros were not ignored.

Accesses to the partial last bank, to the set and clear ports, to a missing bank and to unused offsets check that unused bits stay at zero and that the interleaved map does not alias. A scrambled stretch of toggles and writes is compared against a reference model on every clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int LANES = 32;

  typedef enum logic [2:0] {
    SL_LEVEL = 3'd0,
    SL_DIR   = 3'd1,
    SL_SET   = 3'd2,
    SL_CLR   = 3'd3,
    SL_RISE  = 3'd4,
    SL_FALL  = 3'd5,
    SL_STAT  = 3'd6,
    SL_MASK  = 3'd7
  } reg_slot_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= raw;
      stage2 <= stage1;
    end
  end

  assign synced = stage2;
endmodule

// File: rtl/gpio_addr_map.sv
module gpio_addr_map
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NB     = 7,
  parameter int BANK_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output reg_slot_e         slot,
  output logic              hit
);
  localparam int GRP_W = ADDR_W - 8;
  localparam int BN_W  = GRP_W + 2;

  logic [5:0]       word;
  logic [GRP_W-1:0] grp;
  logic [4:0]       slot_num;
  logic [1:0]       sub;
  logic [BN_W-1:0]  bnum;
  logic             slot_ok;

  always_comb begin
    word     = addr[7:2];
    grp      = addr[ADDR_W-1:8];
    slot_num = 5'(word / 6'd3);
    sub      = 2'(word % 6'd3);
    bnum     = BN_W'({grp, 1'b0}) + BN_W'(grp) + BN_W'(sub);
    slot_ok  = 1'b1;
    case (slot_num)
      5'd0:    slot = SL_LEVEL;
      5'd1:    slot = SL_DIR;
      5'd2:    slot = SL_SET;
      5'd3:    slot = SL_CLR;
      5'd4:    slot = SL_RISE;
      5'd5:    slot = SL_FALL;
      5'd6:    slot = SL_STAT;
      5'd13:   slot = SL_MASK;
      default: begin
        slot    = SL_LEVEL;
        slot_ok = 1'b0;
      end
    endcase
    hit  = slot_ok && (addr[1:0] == 2'b00) && (bnum < BN_W'(NB));
    bank = BANK_W'(bnum);
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter logic [31:0] LANE_MASK = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] level,
  input  logic        we_dir,
  input  logic        we_set,
  input  logic        we_clr,
  input  logic        we_rise,
  input  logic        we_fall,
  input  logic        we_stat,
  input  logic        we_mask,
  input  logic [31:0] wdata,
  output logic [31:0] out_q,
  output logic [31:0] dir_q,
  output logic [31:0] rise_q,
  output logic [31:0] fall_q,
  output logic [31:0] stat_q,
  output logic [31:0] mask_q
);
  logic [31:0] prev_q;
  logic [31:0] new_edge;
  logic [31:0] clr_vec;
  logic [31:0] wd_lanes;

  assign wd_lanes = wdata & LANE_MASK;
  assign clr_vec  = we_stat ? wdata : 32'd0;
  assign new_edge = mask_q & ((level & ~prev_q & rise_q) | (~level & prev_q & fall_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      mask_q <= LANE_MASK;
      prev_q <= '0;
    end else begin
      if (we_set)  out_q  <= out_q | wd_lanes;
      if (we_clr)  out_q  <= out_q & ~wdata;
      if (we_dir)  dir_q  <= wd_lanes;
      if (we_rise) rise_q <= wd_lanes;
      if (we_fall) fall_q <= wd_lanes;
      if (we_mask) mask_q <= wd_lanes;
      stat_q <= (stat_q & ~clr_vec) | new_edge;
      prev_q <= level;
    end
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    we_set |=> ((out_q & $past(wd_lanes)) == $past(wd_lanes)));
  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    we_clr |=> ((out_q & $past(wdata)) == 32'd0));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (|stat_q) |=> ((stat_q & $past(stat_q & ~clr_vec)) == $past(stat_q & ~clr_vec)));
  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (|(~mask_q & ~stat_q)) |=> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == 32'd0));
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|new_edge) |=> ((stat_q & $past(new_edge)) == $past(new_edge)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 224,
  localparam int NB      = (NUM_PINS + LANES - 1) / LANES,
  localparam int GROUPS  = (NB + 2) / 3,
  localparam int ADDR_W  = 8 + ((GROUPS > 1) ? $clog2(GROUPS) : 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_any,
  output logic                irq_pin0,
  output logic                irq_pin1
);
  localparam int PAD    = NB * LANES;
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1;

  function automatic logic [31:0] lane_mask(input int b);
    logic [31:0] m;
    for (int i = 0; i < LANES; i++) m[i] = ((b * LANES + i) < NUM_PINS);
    return m;
  endfunction

  logic [NUM_PINS-1:0] lvl_sync;
  logic [PAD-1:0]      lvl_pad;
  logic [PAD-1:0]      out_flat;
  logic [PAD-1:0]      dir_flat;
  logic [PAD-1:0]      stat_flat;
  logic [BANK_W-1:0]   dec_bank;
  reg_slot_e           dec_slot;
  logic                dec_hit;
  logic [31:0]         rd_next;

  logic [31:0] r_out  [NB];
  logic [31:0] r_dir  [NB];
  logic [31:0] r_rise [NB];
  logic [31:0] r_fall [NB];
  logic [31:0] r_stat [NB];
  logic [31:0] r_mask [NB];
  logic [31:0] r_lvl  [NB];

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .raw(pin_in), .synced(lvl_sync)
  );

  generate
    if (PAD > NUM_PINS) begin : g_pad
      assign lvl_pad = {{(PAD - NUM_PINS){1'b0}}, lvl_sync};
    end else begin : g_nopad
      assign lvl_pad = lvl_sync;
    end
  endgenerate

  gpio_addr_map #(.ADDR_W(ADDR_W), .NB(NB), .BANK_W(BANK_W)) u_map (
    .addr(bus_addr), .bank(dec_bank), .slot(dec_slot), .hit(dec_hit)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      logic sel;
      assign sel = bus_wr && dec_hit && (dec_bank == BANK_W'(b));

      gpio_bank_regs #(.LANE_MASK(lane_mask(b))) u_regs (
        .clk(clk), .rst(rst),
        .level(lvl_pad[b*LANES +: LANES]),
        .we_dir (sel && (dec_slot == SL_DIR)),
        .we_set (sel && (dec_slot == SL_SET)),
        .we_clr (sel && (dec_slot == SL_CLR)),
        .we_rise(sel && (dec_slot == SL_RISE)),
        .we_fall(sel && (dec_slot == SL_FALL)),
        .we_stat(sel && (dec_slot == SL_STAT)),
        .we_mask(sel && (dec_slot == SL_MASK)),
        .wdata(bus_wdata),
        .out_q(r_out[b]), .dir_q(r_dir[b]), .rise_q(r_rise[b]),
        .fall_q(r_fall[b]), .stat_q(r_stat[b]), .mask_q(r_mask[b])
      );

      assign r_lvl[b]                   = lvl_pad[b*LANES +: LANES];
      assign out_flat[b*LANES +: LANES]  = r_out[b];
      assign dir_flat[b*LANES +: LANES]  = r_dir[b];
      assign stat_flat[b*LANES +: LANES] = r_stat[b];
    end
  endgenerate

  assign pin_out = out_flat[NUM_PINS-1:0];
  assign pin_oe  = dir_flat[NUM_PINS-1:0];

  always_comb begin
    rd_next = 32'd0;
    if (dec_hit) begin
      case (dec_slot)
        SL_LEVEL: rd_next = r_lvl[dec_bank];
        SL_DIR:   rd_next = r_dir[dec_bank];
        SL_RISE:  rd_next = r_rise[dec_bank];
        SL_FALL:  rd_next = r_fall[dec_bank];
        SL_STAT:  rd_next = r_stat[dec_bank];
        SL_MASK:  rd_next = r_mask[dec_bank];
        default:  rd_next = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_any   <= 1'b0;
      irq_pin0  <= 1'b0;
      irq_pin1  <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq_any   <= |stat_flat;
      irq_pin0  <= stat_flat[0];
      irq_pin1  <= stat_flat[1];
    end
  end

  assert_unmapped_R1: assert property (@(posedge clk) disable iff (rst)
    !dec_hit |=> (bus_rdata == 32'd0));
  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (rst)
    (|stat_flat) |=> irq_any);
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(|stat_flat) |=> !irq_any);
  assert_irq_pin0_R9: assert property (@(posedge clk) disable iff (rst)
    stat_flat[0] |=> irq_pin0);
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  localparam int NP = 120;
  localparam int NB = 4;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq_any, irq_pin0, irq_pin1;

  gpio_bank_ctrl #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_any(irq_any),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1)
  );

  always #2.5 clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    done = 0;
  bit    seen_rst = 0;
  string phase = "R10";

  bit [31:0]  m_out[NB], m_dir[NB], m_rise[NB], m_fall[NB], m_stat[NB], m_mask[NB];
  bit [127:0] m_s1, m_s2, m_prev;
  bit [31:0]  exp_rd;
  bit         exp_any, exp_i0, exp_i1;

  function automatic bit [31:0] lanes(int b);
    bit [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = ((b * 32 + i) < NP);
    return m;
  endfunction

  function automatic void decode(int a, output int bank, output int slot);
    int w;
    w = (a & 255) >> 2;
    bank = (a >> 8) * 3 + (w % 3);
    slot = w / 3;
    if ((a & 3) != 0 || bank >= NB) slot = -1;
    else if (slot > 6 && slot != 13) slot = -1;
  endfunction

  always @(posedge clk) begin
    int bk, sl;
    bit [31:0] ne[NB];
    bit [31:0] wd;
    if (rst) begin
      seen_rst = 1;
      exp_rd = 0; exp_any = 0; exp_i0 = 0; exp_i1 = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
      for (int b = 0; b < NB; b++) begin
        m_out[b] = 0; m_dir[b] = 0; m_rise[b] = 0; m_fall[b] = 0;
        m_stat[b] = 0; m_mask[b] = lanes(b);
      end
    end else begin
      decode(int'(bus_addr), bk, sl);
      exp_rd = 0;
      if (sl >= 0) begin
        case (sl)
          0: exp_rd = m_s2[bk*32 +: 32];
          1: exp_rd = m_dir[bk];
          4: exp_rd = m_rise[bk];
          5: exp_rd = m_fall[bk];
          6: exp_rd = m_stat[bk];
          13: exp_rd = m_mask[bk];
          default: exp_rd = 0;
        endcase
      end
      exp_any = 0;
      for (int b = 0; b < NB; b++) exp_any |= (m_stat[b] != 0);
      exp_i0 = m_stat[0][0];
      exp_i1 = m_stat[0][1];
      for (int b = 0; b < NB; b++) begin
        bit [31:0] c, p;
        c = m_s2[b*32 +: 32]; p = m_prev[b*32 +: 32];
        ne[b] = m_mask[b] & ((c & ~p & m_rise[b]) | (~c & p & m_fall[b]));
      end
      if (bus_wr && sl >= 0) begin
        wd = bus_wdata & lanes(bk);
        case (sl)
          1: m_dir[bk] = wd;
          2: m_out[bk] = m_out[bk] | wd;
          3: m_out[bk] = m_out[bk] & ~bus_wdata;
          4: m_rise[bk] = wd;
          5: m_fall[bk] = wd;
          6: m_stat[bk] = m_stat[bk] & ~bus_wdata;
          13: m_mask[bk] = wd;
          default: ;
        endcase
      end
      for (int b = 0; b < NB; b++) m_stat[b] = m_stat[b] | ne[b];
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = {8'd0, pin_in};
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (seen_rst && !done) begin
      logic [127:0] eo, ee;
      eo = {m_out[3], m_out[2], m_out[1], m_out[0]};
      ee = {m_dir[3], m_dir[2], m_dir[1], m_dir[0]};
      chk({phase, " rdata R11"}, 128'(bus_rdata), 128'(exp_rd));
      chk({phase, " pin_out R2"}, 128'(pin_out), 128'(eo[NP-1:0]));
      chk({phase, " pin_oe R3"}, 128'(pin_oe), 128'(ee[NP-1:0]));
      chk({phase, " irqs R9"}, 128'({irq_any, irq_pin0, irq_pin1}),
          128'({exp_any, exp_i0, exp_i1}));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = AW'(a); bus_wr = 1'b0;
    @(negedge clk);
    chk(tag, 128'(bus_rdata), 128'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R10 reset state
    phase = "R10";
    rd(12'h09C, 32'hFFFF_FFFF, "R10 mask bank0 reset");
    rd(12'h19C, 32'h00FF_FFFF, "R10 mask partial bank3 reset");
    rd(12'h010, 32'h0, "R10 dir bank1 reset");
    // R2 set/clear ports
    phase = "R2";
    wr(12'h020, 32'hA5A5_A5A5);
    chk("R2 set bank2", 128'(pin_out[95:64]), 128'(32'hA5A5_A5A5));
    wr(12'h02C, 32'h0000_FFFF);
    chk("R2 clear bank2", 128'(pin_out[95:64]), 128'(32'hA5A5_0000));
    wr(12'h020, 32'h0);
    chk("R2 zero set no effect", 128'(pin_out[95:64]), 128'(32'hA5A5_0000));
    // R1 map
    phase = "R1";
    rd(12'h020, 32'h0, "R1 set port reads 0");
    rd(12'h02C, 32'h0, "R1 clear port reads 0");
    wr(12'h014, 32'h1234_5678);
    rd(12'h014, 32'h1234_5678, "R1 dir bank2");
    rd(12'h010, 32'h0, "R1 dir bank1 untouched");
    rd(12'h060, 32'h0, "R1 unused offset");
    rd(12'h104, 32'h0, "R1 missing bank4");
    rd(12'h015, 32'h0, "R1 misaligned");
    // R3 / R10 partial bank
    phase = "R3";
    wr(12'h10C, 32'hFFFF_FFFF);
    rd(12'h10C, 32'h00FF_FFFF, "R10 dir bank3 lane clip");
    chk("R3 pin_oe bank3", 128'(pin_oe[119:96]), 128'(24'hFF_FFFF));
    // R4 level readback on output pins
    phase = "R4";
    pin_in[119:96] = 24'hAB_CDEF;
    idle(3);
    rd(12'h100, 32'h00AB_CDEF, "R4 level bank3");
    // R5 independent enables
    phase = "R5";
    wr(12'h034, 32'h0000_00A0);
    wr(12'h040, 32'h0000_00C0);
    pin_in[39:37] = 3'b111;
    idle(4);
    rd(12'h04C, 32'h0000_00A0, "R5 rising only");
    pin_in[39:37] = 3'b000;
    idle(4);
    rd(12'h04C, 32'h0000_00E0, "R5 falling added");
    // R6 sticky w1c
    phase = "R6";
    wr(12'h04C, 32'h0);
    rd(12'h04C, 32'h0000_00E0, "R6 zero write no effect");
    wr(12'h04C, 32'h0000_0020);
    rd(12'h04C, 32'h0000_00C0, "R6 one clears bit");
    wr(12'h04C, 32'hFFFF_FFFF);
    rd(12'h04C, 32'h0, "R6 all cleared");
    // R7 mask
    phase = "R7";
    wr(12'h09C, 32'hFFFF_FFF7);
    wr(12'h030, 32'h0000_0008);
    pin_in[3] = 1'b1;
    idle(4);
    rd(12'h048, 32'h0, "R7 masked edge dropped");
    chk("R7 no irq", 128'(irq_any), 128'(0));
    wr(12'h09C, 32'hFFFF_FFFF);
    pin_in[3] = 1'b0;
    idle(3);
    pin_in[3] = 1'b1;
    idle(4);
    rd(12'h048, 32'h0000_0008, "R7 unmasked edge seen");
    wr(12'h048, 32'h0000_0008);
    // R8 edge wins over clear
    phase = "R8";
    wr(12'h030, 32'h0000_0001);
    idle(2);
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_addr = AW'(12'h048); bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(12'h048, 32'h0000_0001, "R8 edge kept over clear");
    chk("R9 irq_pin0", 128'(irq_pin0), 128'(1));
    chk("R9 irq_pin1 idle", 128'(irq_pin1), 128'(0));
    wr(12'h048, 32'h1);
    rd(12'h048, 32'h0, "R6 cleared after");
    // R9 pin1 and aggregate
    phase = "R9";
    wr(12'h030, 32'h0000_0002);
    pin_in[1] = 1'b1;
    idle(5);
    chk("R9 irq_pin1", 128'(irq_pin1), 128'(1));
    chk("R9 irq_any", 128'(irq_any), 128'(1));
    wr(12'h048, 32'h2);
    idle(2);
    chk("R9 irq_any drops", 128'(irq_any), 128'(0));
    // scrambled stretch, compared per cycle
    phase = "R5 mix";
    wr(12'h030, 32'hFFFF_FFFF); wr(12'h040, 32'h0F0F_F0F0);
    wr(12'h134, 32'hFFFF_FFFF); wr(12'h044, 32'hFFFF_0000);
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk);
      pin_in[lf[6:0] % NP] = ~pin_in[lf[6:0] % NP];
      if (lf[15:13] == 3'b101) begin
        bus_addr = AW'({lf[8], 8'h48} + {7'd0, lf[10:9] % 2'd3, 2'b00});
        bus_wdata = {lf, lf}; bus_wr = 1'b1;
      end else if (lf[15:13] == 3'b011) begin
        bus_addr = AW'({lf[8], 8'h18} + {7'd0, lf[10:9] % 2'd3, 2'b00});
        bus_wdata = {lf, ~lf}; bus_wr = 1'b1;
      end else begin
        bus_addr = AW'({lf[8], 2'b00, lf[5:0]} & 9'h1FC); bus_wr = 1'b0;
      end
    end
    @(negedge clk); bus_wr = 1'b0;
    idle(4);
    finish_run();
  end
endmodule